// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Operation Decoder

This block is the execution core of a small load/store processor pipeline. It is purely combinational: from two word-wide operands, a separate shift-distance field and the opcode and function fields of the current instruction, it produces one word-wide result and a flag that is high when that result is zero. The branch unit uses the flag for equality tests.

A decoder turns the instruction fields into an internal operation select. One shared adder handles addition, subtraction and both magnitude comparisons. Comparisons give a full word holding 1 or 0, and no condition codes are kept. There is no dedicated inversion: software gets the bitwise inverse by applying NOR against a zero operand. Shifts are logical only. They take their distance from the shift-amount field and move operand A; operand B plays no part in a shift.

The datapath width is a parameter (default 32). The shifter can be built as a staged logarithmic network or as a single shift operator.

Top module: `int_alu_core`

## Requirements
- R1: ADD gives (A + B) mod 2^W with no overflow indication. It is selected by opcode 0x00 with function 0x20, and by opcodes 0x08 (add immediate), 0x23 (load) and 0x2B (store).
- R2: SUB gives (A + ~B + 1) mod 2^W. It is selected by opcode 0x00 with function 0x22, and by opcodes 0x04 and 0x05 (equal and not-equal branches).
- R3: AND gives A & B (function 0x24 or opcode 0x0C). OR gives A | B (function 0x25 or opcode 0x0D).
- R4: NOR gives ~(A | B) (function 0x27). With B = 0 the result is the bitwise inverse of A.
- R5: Signed set-less-than (function 0x2A or opcode 0x0A) gives the word 1 when A < B as two's complement values, and 0 otherwise. Bits W-1..1 of the result are always 0.
- R6: Unsigned set-less-than (function 0x2B or opcode 0x0B) gives the word 1 when A < B as values from 0 to 2^W-1, and 0 otherwise.
- R7: Shift left (function 0x00) gives A shifted left by the shift-amount field, with vacated bits filled with 0. B has no effect.
- R8: Shift right (function 0x02) gives A shifted right by the shift-amount field, with vacated high bits filled with 0. B has no effect.
- R9: The zero flag is 1 exactly when all W bits of the result are 0.
- R10: Any function code under opcode 0x00, or any opcode, not listed above performs ADD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary operation field of the instruction |
| funct | input | 6 | Function field, decoded when opcode is 0x00 |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (already extended when it is an immediate) |
| shamt | input | $clog2(WIDTH) | Shift distance |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
On every evaluation, the embedded checks compare the shared adder's difference against the operands and its two less-than outputs against independent signed and unsigned comparisons. They also check that the shifter agrees with a plain shift operator and that a comparison result never sets a bit above bit 0. The bench scenarios are the only place that shows decoding is correct: each opcode and function code reaching the right operation, unlisted codes falling back to addition, and operand B being ignored by shifts. The scenarios also cover the wrap and sign corner cases (carry out of the top bit, most-negative against positive, maximum shift distance) and the zero flag after a branch-style subtraction.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_AND  = 4'd2,
      ALU_OR   = 4'd3,
      ALU_NOR  = 4'd4,
      ALU_SLT  = 4'd5,
      ALU_SLTU = 4'd6,
      ALU_SLL  = 4'd7,
      ALU_SRL  = 4'd8
   } alu_op_e;

   localparam int CODE_W = 6;

   // primary opcodes
   localparam logic [CODE_W-1:0] OPC_REG   = 6'h00;
   localparam logic [CODE_W-1:0] OPC_BEQ   = 6'h04;
   localparam logic [CODE_W-1:0] OPC_BNE   = 6'h05;
   localparam logic [CODE_W-1:0] OPC_ADDI  = 6'h08;
   localparam logic [CODE_W-1:0] OPC_SLTI  = 6'h0A;
   localparam logic [CODE_W-1:0] OPC_SLTIU = 6'h0B;
   localparam logic [CODE_W-1:0] OPC_ANDI  = 6'h0C;
   localparam logic [CODE_W-1:0] OPC_ORI   = 6'h0D;
   localparam logic [CODE_W-1:0] OPC_LOAD  = 6'h23;
   localparam logic [CODE_W-1:0] OPC_STORE = 6'h2B;

   // function codes under OPC_REG
   localparam logic [CODE_W-1:0] FN_SLL  = 6'h00;
   localparam logic [CODE_W-1:0] FN_SRL  = 6'h02;
   localparam logic [CODE_W-1:0] FN_ADD  = 6'h20;
   localparam logic [CODE_W-1:0] FN_SUB  = 6'h22;
   localparam logic [CODE_W-1:0] FN_AND  = 6'h24;
   localparam logic [CODE_W-1:0] FN_OR   = 6'h25;
   localparam logic [CODE_W-1:0] FN_NOR  = 6'h27;
   localparam logic [CODE_W-1:0] FN_SLT  = 6'h2A;
   localparam logic [CODE_W-1:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [CODE_W-1:0] opcode,
   input  logic [CODE_W-1:0] funct,
   output alu_op_e           op_sel
);

   alu_op_e reg_op;

   always_comb begin
      case (funct)
         FN_SLL:  reg_op = ALU_SLL;
         FN_SRL:  reg_op = ALU_SRL;
         FN_ADD:  reg_op = ALU_ADD;
         FN_SUB:  reg_op = ALU_SUB;
         FN_AND:  reg_op = ALU_AND;
         FN_OR:   reg_op = ALU_OR;
         FN_NOR:  reg_op = ALU_NOR;
         FN_SLT:  reg_op = ALU_SLT;
         FN_SLTU: reg_op = ALU_SLTU;
         default: reg_op = ALU_ADD;   // R10
      endcase
   end

   always_comb begin
      case (opcode)
         OPC_REG:   op_sel = reg_op;
         OPC_BEQ,
         OPC_BNE:   op_sel = ALU_SUB;
         OPC_SLTI:  op_sel = ALU_SLT;
         OPC_SLTIU: op_sel = ALU_SLTU;
         OPC_ANDI:  op_sel = ALU_AND;
         OPC_ORI:   op_sel = ALU_OR;
         OPC_ADDI,
         OPC_LOAD,
         OPC_STORE: op_sel = ALU_ADD;
         default:   op_sel = ALU_ADD; // R10
      endcase
   end

   always_comb begin
      if (!$isunknown(opcode)) begin
         // R2
         branch_sub_chk: assert (!(opcode == OPC_BEQ || opcode == OPC_BNE) || op_sel == ALU_SUB)
            else $error("branch opcode did not select subtract");
      end
   end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             lt_s,
   output logic             lt_u
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   full;
   logic             carry;

   assign b_eff = sub ? ~b : b;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
   assign sum   = full[WIDTH-1:0];
   assign carry = full[WIDTH];

   // differing signs decide directly; equal signs use the difference sign
   assign lt_s = (a[MSB] ^ b[MSB]) ? a[MSB] : sum[MSB];
   // no carry out of A + ~B + 1 means a borrow, i.e. A < B unsigned
   assign lt_u = ~carry;

   always_comb begin
      if (!$isunknown({a, b, sub}) && sub) begin
         // R2
         sub_inverse_chk: assert (sum + b == a)
            else $error("difference plus B does not give A");
         // R5
         slt_signed_chk: assert (lt_s == ($signed(a) < $signed(b)))
            else $error("signed compare mismatch");
         // R6
         slt_unsigned_chk: assert (lt_u == (a < b))
            else $error("unsigned compare mismatch");
      end
   end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
   parameter int WIDTH       = 32,
   parameter bit STAGED_IMPL = 1'b1,
   localparam int SHW        = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SHW-1:0]   amt,
   input  logic             left,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGED_IMPL) begin : g_staged
         logic [WIDTH-1:0] stage [SHW+1];
         assign stage[0] = din;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            logic [WIDTH-1:0] moved;
            assign moved        = left ? (stage[s] << DIST) : (stage[s] >> DIST);
            assign stage[s+1]   = amt[s] ? moved : stage[s];
         end
         assign dout = stage[SHW];
      end else begin : g_operator
         assign dout = left ? (din << amt) : (din >> amt);
      end
   endgenerate

   always_comb begin
      if (!$isunknown({din, amt, left})) begin
         // R7
         shl_fill_chk: assert (!left || dout == (din << amt))
            else $error("left shift mismatch");
         // R8
         shr_fill_chk: assert (left || dout == (din >> amt))
            else $error("right shift mismatch");
      end
   end

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int WIDTH         = 32,
   parameter bit STAGED_SHIFT  = 1'b1,
   localparam int SHW          = $clog2(WIDTH)
) (
   input  logic [CODE_W-1:0] opcode,
   input  logic [CODE_W-1:0] funct,
   input  logic [WIDTH-1:0]  opnd_a,
   input  logic [WIDTH-1:0]  opnd_b,
   input  logic [SHW-1:0]    shamt,
   output logic [WIDTH-1:0]  result,
   output logic              zero
);

   initial begin
      if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0)
         $error("int_alu_core: WIDTH must be a power of two of at least 8");
   end

   alu_op_e          op_sel;
   logic [WIDTH-1:0] sum;
   logic             lt_s;
   logic             lt_u;
   logic [WIDTH-1:0] shifted;
   logic             do_sub;

   int_alu_decode u_dec (
      .opcode (opcode),
      .funct  (funct),
      .op_sel (op_sel)
   );

   // subtract path also feeds both comparisons
   assign do_sub = (op_sel != ALU_ADD);

   int_alu_addsub #(.WIDTH(WIDTH)) u_add (
      .a    (opnd_a),
      .b    (opnd_b),
      .sub  (do_sub),
      .sum  (sum),
      .lt_s (lt_s),
      .lt_u (lt_u)
   );

   int_alu_shift #(.WIDTH(WIDTH), .STAGED_IMPL(STAGED_SHIFT)) u_shf (
      .din  (opnd_a),
      .amt  (shamt),
      .left (op_sel == ALU_SLL),
      .dout (shifted)
   );

   always_comb begin
      case (op_sel)
         ALU_ADD,
         ALU_SUB:  result = sum;
         ALU_AND:  result = opnd_a & opnd_b;
         ALU_OR:   result = opnd_a | opnd_b;
         ALU_NOR:  result = ~(opnd_a | opnd_b);
         ALU_SLT:  result = {{(WIDTH-1){1'b0}}, lt_s};
         ALU_SLTU: result = {{(WIDTH-1){1'b0}}, lt_u};
         ALU_SLL,
         ALU_SRL:  result = shifted;
         default:  result = sum;
      endcase
   end

   assign zero = ~|result;

   always_comb begin
      if (!$isunknown({opcode, funct, opnd_a, opnd_b})) begin
         // R5
         slt_word_chk: assert (!(op_sel == ALU_SLT || op_sel == ALU_SLTU) || result[WIDTH-1:1] == '0)
            else $error("compare result has high bits set");
         // R4
         nor_invert_chk: assert (!(op_sel == ALU_NOR && opnd_b == '0) || (result ^ opnd_a) == '1)
            else $error("NOR against zero is not the inverse of A");
      end
   end

endmodule

// File: tb/sim_int_alu_core.sv
module sim_int_alu_core;
   import int_alu_pkg::*;

   localparam int W   = 32;
   localparam int SHW = $clog2(W);

   typedef struct {
      logic [W-1:0] res;
      string        tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   logic [5:0]     opcode = '0;
   logic [5:0]     funct  = '0;
   logic [W-1:0]   opnd_a = '0;
   logic [W-1:0]   opnd_b = '0;
   logic [SHW-1:0] shamt  = '0;
   logic [W-1:0]   result;
   logic           zero;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   exp_t sb[$];

   int_alu_core #(.WIDTH(W)) u0 (
      .opcode (opcode), .funct (funct), .opnd_a (opnd_a),
      .opnd_b (opnd_b), .shamt (shamt), .result (result), .zero (zero)
   );

   task automatic drive(input logic [5:0] opc, input logic [5:0] fn,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [SHW-1:0] sh, input logic [W-1:0] exp_res,
                        input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      opcode = opc; funct = fn; opnd_a = a; opnd_b = b; shamt = sh;
      e.res = exp_res; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compare at the falling edge, inputs settled since posedge+1
   always @(negedge clk) begin
      if (!rst && sb.size() > 0) begin
         exp_t e;
         logic z_exp;
         e = sb.pop_front();
         z_exp = (e.res == '0);
         total++;
         if (result !== e.res || zero !== z_exp) begin
            bad++;
            $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                     e.tag, result, zero, e.res, z_exp);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // quiescent inputs: add of zeros
      drive(6'h00, 6'h20, 32'h0, 32'h0, 5'd0, 32'h0, "R9 idle zero flag");
      // R1 add
      drive(6'h00, 6'h20, 32'h7FFF_FFFF, 32'h1, 5'd0, 32'h8000_0000, "R1 add into sign bit");
      drive(6'h00, 6'h20, 32'hFFFF_FFFF, 32'h1, 5'd0, 32'h0, "R1 R9 add wrap to zero");
      drive(6'h08, 6'h3F, 32'd5, 32'd7, 5'd0, 32'd12, "R1 add immediate");
      drive(6'h23, 6'h11, 32'h1000, 32'h20, 5'd0, 32'h1020, "R1 load address");
      drive(6'h2B, 6'h00, 32'h1000, 32'hFFFF_FFFC, 5'd3, 32'h0FFC, "R1 store address");
      // R2 subtract
      drive(6'h00, 6'h22, 32'd10, 32'd3, 5'd0, 32'd7, "R2 sub positive");
      drive(6'h00, 6'h22, 32'd3, 32'd10, 5'd0, 32'hFFFF_FFF9, "R2 sub negative");
      drive(6'h04, 6'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd9, 32'h0, "R2 R9 branch equal");
      drive(6'h05, 6'h00, 32'h5, 32'h4, 5'd0, 32'h1, "R2 R9 branch differ");
      // R3 and/or
      drive(6'h00, 6'h24, 32'h3C00, 32'h0DC0, 5'd0, 32'h0C00, "R3 and");
      drive(6'h00, 6'h25, 32'h3C00, 32'h0DC0, 5'd0, 32'h3DC0, "R3 or");
      drive(6'h0C, 6'h00, 32'hFFFF_00F0, 32'h0000_FFFF, 5'd0, 32'h0000_00F0, "R3 and immediate");
      drive(6'h0D, 6'h00, 32'h007D_0000, 32'h0000_0900, 5'd0, 32'h007D_0900, "R3 or immediate");
      // R4 nor
      drive(6'h00, 6'h27, 32'h3C00, 32'h0, 5'd0, 32'hFFFF_C3FF, "R4 nor as invert");
      drive(6'h00, 6'h27, 32'hF0F0_0000, 32'h0F0F_0000, 5'd0, 32'h0000_FFFF, "R4 nor general");
      // R5 signed compare
      drive(6'h00, 6'h2A, 32'hFFFF_FFFC, 32'd2, 5'd0, 32'd1, "R5 neg below pos");
      drive(6'h00, 6'h2A, 32'd2, 32'hFFFF_FFFC, 5'd0, 32'd0, "R5 pos not below neg");
      drive(6'h00, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd1, "R5 extremes");
      drive(6'h0A, 6'h00, 32'd7, 32'd7, 5'd0, 32'd0, "R5 equal immediate");
      // R6 unsigned compare
      drive(6'h00, 6'h2B, 32'hFFFF_FFFC, 32'd2, 5'd0, 32'd0, "R6 large not below small");
      drive(6'h00, 6'h2B, 32'd2, 32'hFFFF_FFFC, 5'd0, 32'd1, "R6 small below large");
      drive(6'h0B, 6'h00, 32'd0, 32'd1, 5'd0, 32'd1, "R6 immediate");
      // R7 shift left, B ignored
      drive(6'h00, 6'h00, 32'h3, 32'hFFFF_FFFF, 5'd4, 32'h30, "R7 shl by 4 B ignored");
      drive(6'h00, 6'h00, 32'h1, 32'h1234_5678, 5'd31, 32'h8000_0000, "R7 shl max");
      drive(6'h00, 6'h00, 32'hA5A5_A5A5, 32'h0, 5'd0, 32'hA5A5_A5A5, "R7 shl by 0");
      drive(6'h00, 6'h00, 32'h8000_0000, 32'h0, 5'd1, 32'h0, "R7 R9 shl out");
      // R8 shift right, B ignored
      drive(6'h00, 6'h02, 32'h8000_0000, 32'hFFFF_FFFF, 5'd31, 32'h1, "R8 shr max zero fill");
      drive(6'h00, 6'h02, 32'hF0, 32'hABCD_0000, 5'd4, 32'hF, "R8 shr by 4 B ignored");
      // R10 unlisted codes
      drive(6'h00, 6'h3F, 32'd100, 32'd23, 5'd2, 32'd123, "R10 unknown function adds");
      drive(6'h3F, 6'h22, 32'd100, 32'd23, 5'd0, 32'd123, "R10 unknown opcode adds");
      repeat (3) @(posedge clk);
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule